// File: doc/BRIEF.md
# Dual-Algorithm Comparator-Search Converter Controller

This block is the control side of an analog-to-digital converter built from an external DAC and an analog comparator. The comparator sees the unknown signal on one input and the DAC output on the other. The block drives trial codes onto the DAC. After each code change it waits a programmable number of clocks so that the DAC and comparator can settle. It then samples the single comparator bit and decides on the next trial code.

Two search algorithms are available, and the choice is taken at start time. The linear ramp begins at the lowest code and climbs one step per trial until the comparator flips. The binary search resolves one bit per trial, from the most significant bit down. When a conversion ends, the block registers the code, raises a one-cycle done strobe and freezes a count of the clocks the conversion used, so that the cost of the two algorithms can be compared directly.

Top module: `sweep_adc_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `result`, `dac_code` and `conv_cycles` are all zero.
- R2: A `start` pulse while idle sets `busy` on the next clock edge and loads the first trial code. With `mode` = 0 (ramp) the first code is 0. With `mode` = 1 (binary search) it is 128 (only bit 7 set).
- R3: Every trial code stays on `dac_code` for exactly `settle_cycles`+1 clocks. The comparator is sampled only on the last of those clocks.
- R4: In ramp mode the code rises by one per trial. The conversion ends at the first trial where `cmp_hi` (1 = input above DAC output) reads 0, and that code is the result.
- R5: In ramp mode, if `cmp_hi` is still 1 at code 255, the conversion ends there and returns 255.
- R6: In binary-search mode, bits are tried from bit 7 to bit 0. A trial bit is kept only if `cmp_hi` is 1. Exactly 8 trials are made, and the result is the largest code below the input (0 if none).
- R7: `done` is high for exactly one clock. On that clock `busy` falls and `result` takes the new value, which then holds until the next conversion ends.
- R8: `conv_cycles` is cleared at start, equals trials × (`settle_cycles`+1) when `done` rises, and stays unchanged while idle.
- R9: A `start` pulse while `busy` is high has no effect on the code sequence, the result or the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (ignored while busy) |
| mode | input | 1 | 0 = linear ramp, 1 = binary search; latched at start |
| settle_cycles | input | SETTLE_W | Extra clocks of settling after each code change |
| cmp_hi | input | 1 | Comparator: 1 when input is above the DAC output |
| dac_code | output | CODE_W | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion strobe |
| result | output | CODE_W | Last conversion result |
| conv_cycles | output | CNT_W | Clocks used by the last or current conversion |

## Verification
The hardest case to reach is the ramp saturation of R5. The comparator must stay high through every code, including the last one, and that code is also where the ramp would normally stop. The bench models the comparator with an input level held at half-code resolution and sweeps it across the full range, including the two top levels, so that both the saturation exit and the ordinary exit on code 255 occur. A second start pulse is injected in the middle of some conversions to show that it is ignored.

// File: rtl/sweep_adc_pkg.sv
package sweep_adc_pkg;
  typedef enum logic {
    SRCH_RAMP = 1'b0,
    SRCH_BIN  = 1'b1
  } srch_mode_t;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_state_t;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                expired
);
  logic [SETTLE_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  // R3: the count only moves down between loads
  a_r3_timer_down: assert property (@(posedge clk) disable iff (rst)
    (!load && remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/code_search.sv
module code_search
  import sweep_adc_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int IDX_W = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  srch_mode_t        init_mode,
  input  logic              step,
  input  logic              cmp_hi,
  output logic [CODE_W-1:0] code,
  output logic              last,
  output logic [CODE_W-1:0] final_code
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MSB = {1'b1, {(CODE_W-1){1'b0}}};

  srch_mode_t        mode_q;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] bit_mask;
  logic [CODE_W-1:0] next_mask;

  always_comb begin
    bit_mask  = '0;
    next_mask = '0;
    bit_mask[idx] = 1'b1;
    if (idx != '0) next_mask[idx - 1'b1] = 1'b1;
  end

  always_comb begin
    if (mode_q == SRCH_RAMP) begin
      last       = !cmp_hi || (code == CODE_MAX);
      final_code = code;
    end else begin
      last       = (idx == '0);
      final_code = cmp_hi ? code : (code & ~bit_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SRCH_RAMP;
      idx    <= '0;
      code   <= '0;
    end else if (init) begin
      mode_q <= init_mode;
      idx    <= IDX_W'(CODE_W - 1);
      code   <= (init_mode == SRCH_RAMP) ? '0 : CODE_MSB;
    end else if (step && !last) begin
      if (mode_q == SRCH_RAMP) begin
        code <= code + 1'b1;
      end else begin
        code <= final_code | next_mask;
        idx  <= idx - 1'b1;
      end
    end
  end

  // R4: the ramp never moves downward except on a new start
  a_r4_ramp_rises: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SRCH_RAMP && !init) |=> (code >= $past(code)));
  // R6: each binary-search trial moves to the next lower bit
  a_r6_bit_walk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SRCH_BIN && step && !last && !init) |=> (idx == $past(idx) - 1'b1));
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (clear) count <= '0;
    else if (run)   count <= count + 1'b1;
  end

  // R8: frozen while idle
  a_r8_frozen_idle: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(count));
  // R8: one increment per busy clock
  a_r8_counts_busy: assert property (@(posedge clk) disable iff (rst)
    (run && !clear) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/sweep_adc_ctrl.sv
module sweep_adc_ctrl
  import sweep_adc_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 4,
  localparam int CNT_W   = CODE_W + SETTLE_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                mode,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                cmp_hi,
  output logic [CODE_W-1:0]   dac_code,
  output logic                busy,
  output logic                done,
  output logic [CODE_W-1:0]   result,
  output logic [CNT_W-1:0]    conv_cycles
);
  ctl_state_t        state;
  logic              accept;
  logic              expired;
  logic              last;
  logic              sample;
  logic              tmr_load;
  logic [CODE_W-1:0] final_code;

  assign accept   = (state == CTL_IDLE) && start;
  assign sample   = (state == CTL_RUN) && expired;
  assign tmr_load = accept || (sample && !last);
  assign busy     = (state == CTL_RUN);

  settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (settle_cycles),
    .expired  (expired)
  );

  code_search #(.CODE_W(CODE_W)) u_search (
    .clk        (clk),
    .rst        (rst),
    .init       (accept),
    .init_mode  (srch_mode_t'(mode)),
    .step       (sample),
    .cmp_hi     (cmp_hi),
    .code       (dac_code),
    .last       (last),
    .final_code (final_code)
  );

  cycle_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .run   (busy),
    .count (conv_cycles)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CTL_IDLE;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        CTL_IDLE: if (start) state <= CTL_RUN;
        CTL_RUN: if (expired && last) begin
          state  <= CTL_IDLE;
          done   <= 1'b1;
          result <= final_code;
        end
        default: state <= CTL_IDLE;
      endcase
    end
  end

  // R3: code held while settling
  a_r3_code_held: assert property (@(posedge clk) disable iff (rst)
    (busy && !expired) |=> $stable(dac_code));
  // R7: done is a single-cycle strobe and ends busy
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R7: result changes only with done
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(result) || done));
  // R9: a start during a conversion does not restart the code
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !expired) |=> (busy && $stable(dac_code)));
endmodule

// File: tb/sweep_adc_ctrl_test.sv
module sweep_adc_ctrl_test;
  localparam int CODE_W   = 8;
  localparam int SETTLE_W = 4;
  localparam int CNT_W    = CODE_W + SETTLE_W + 1;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start = 1'b0;
  logic                mode = 1'b0;
  logic [SETTLE_W-1:0] settle_cycles = '0;
  logic                cmp_hi;
  logic [CODE_W-1:0]   dac_code;
  logic                busy;
  logic                done;
  logic [CODE_W-1:0]   result;
  logic [CNT_W-1:0]    conv_cycles;

  int vin_x2 = 0;
  int tests  = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  // comparator model: input level held in half-code units
  always_comb cmp_hi = (vin_x2 > 2 * int'(dac_code));

  sweep_adc_ctrl #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .settle_cycles(settle_cycles), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .busy(busy), .done(done), .result(result), .conv_cycles(conv_cycles)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic run_conv(input int m, input int v, input int s, input int mid_start);
    int exp_res, trials, per, j, prev, bad_hold;
    per = s + 1;
    if (m == 0) begin
      exp_res = (v + 1) / 2;
      if (exp_res > 255) exp_res = 255;
      trials = exp_res + 1;
    end else begin
      exp_res = (v == 0) ? 0 : (v - 1) / 2;
      if (exp_res > 255) exp_res = 255;
      trials = 8;
    end
    mode = m[0];
    vin_x2 = v;
    settle_cycles = s[SETTLE_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    check("R2 first code", int'(dac_code), (m == 0) ? 0 : 128);
    j = 0;
    prev = int'(dac_code);
    bad_hold = 0;
    while (!done && j < 5000) begin
      if (mid_start != 0 && j == mid_start) start = 1'b1; // R9 stimulus
      @(negedge clk);
      start = 1'b0;
      j++;
      if (!done && int'(dac_code) != prev && (j % per) != 0) bad_hold++;
      prev = int'(dac_code);
    end
    if (m == 0) check("R4 R5 ramp result", int'(result), exp_res);
    else        check("R6 binary result", int'(result), exp_res);
    check("R3 code held settle+1 clocks", bad_hold, 0);
    check("R8 cycles at done", int'(conv_cycles), trials * per);
    check("R7 clocks to done", j, trials * per);
    check("R7 busy low with done", int'(busy), 0);
    @(negedge clk);
    check("R7 done single cycle", int'(done), 0);
    check("R7 result held", int'(result), exp_res);
    check("R8 cycles frozen", int'(conv_cycles), trials * per);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);
    check("R1 dac_code", int'(dac_code), 0);
    check("R1 conv_cycles", int'(conv_cycles), 0);
    rst = 1'b0;
    @(negedge clk);

    // R6 full sweep of input level, no settle
    for (int v = 0; v < 512; v++) run_conv(1, v, 0, 0);
    // R4 ramp sweep plus top levels for R5
    for (int v = 0; v < 512; v += 9) run_conv(0, v, 0, 0);
    run_conv(0, 509, 0, 0);
    run_conv(0, 510, 0, 0);
    run_conv(0, 511, 0, 0); // R5 saturation
    // R3 with settle delays
    for (int v = 1; v < 512; v += 37) run_conv(1, v, 2, 0);
    run_conv(0, 21, 3, 0);
    run_conv(0, 80, 15, 0);
    run_conv(1, 300, 15, 0);
    // R9 restart attempts mid-conversion
    run_conv(0, 100, 1, 5);
    run_conv(1, 255, 2, 7);
    run_conv(1, 64, 0, 1);

    finish_run();
  end
endmodule